// File: doc/BRIEF.md
# Mailbox Command/Reply Queue Register Interface

This block is the controller-side register window of a storage adapter running in its simple queueing mode. A host on a 32-bit memory-mapped register bus submits work by writing a command bus address to a request port. Each address enters an inbound queue that the controller engine drains through a valid/ready stream. When the engine finishes a command it pushes a completion tag into an outbound queue, again through a valid/ready stream. The host collects completions by reading a reply port. Each read removes one entry, and a read of an empty queue returns all ones.

Around the two queues sit a few host-visible registers: an interrupt status word, an interrupt mask, a doorbell word, a firmware readiness scratchpad, and two read-only locator words for the configuration tables. The mask works active-high as a disable: writing zero enables the reply interrupt. Both queues hold `MAX_CMDS` entries, the largest number of commands the host may have outstanding. A request written into a full inbound queue is discarded, and a sticky overflow flag records the loss.

Stream rules: `cmd_valid` stays high and `cmd_addr` stays stable until the engine accepts with `cmd_ready`. `cpl_ready` is low while the outbound queue is full, and a completion offered then is not taken. Bus reads have one cycle of latency: data comes back on the cycle after `host_rd`, marked by `host_rvalid`.

Top module: `mbox_regif`

## Requirements
- R1: A host write to byte offset 0x40 appends the written word to the inbound queue. The engine sees the entries in arrival order on `cmd_addr` while `cmd_valid` is high. An entry is removed on a cycle where `cmd_valid` and `cmd_ready` are both high, and `cmd_addr` holds while it waits.
- R2: A write to 0x40 while the inbound queue already holds `MAX_CMDS` entries is discarded, which leaves the queue contents unchanged. The same write sets a sticky overflow flag, read as bit 0 at offset 0x38. Writing a word with bit 0 set to 0x38 clears the flag, and writing bit 0 as zero leaves it set.
- R3: A completion on `cpl_tag` enters the outbound queue on a cycle where `cpl_valid` and `cpl_ready` are both high. `cpl_ready` is low exactly while the outbound queue holds `MAX_CMDS` entries.
- R4: A host read of offset 0x44 returns the oldest outbound entry and removes it. When the outbound queue is empty, the read returns 0xFFFFFFFF and removes nothing.
- R5: Read data appears on `host_rdata` in the cycle after `host_rd` is sampled high. `host_rvalid` is high in exactly those cycles.
- R6: Offset 0x30 reads 0x00000008 (bit 3 set) whenever the outbound queue is non-empty and 0 otherwise, whatever the mask setting.
- R7: The mask word at 0x34 resets to 0x00000008 and reads back the last value written. `irq` is high exactly when the outbound queue is non-empty and bit 3 of the mask word is zero.
- R8: Offset 0xB0 reads 0xFFFF0000 while `fw_ready` is high and 0 while it is low. Offsets 0xB4 and 0xB8 read the parameters `CFG_TABLE_LOC` and `CFG_MEM_LOC`.
- R9: A write to 0x20 stores the full word. The stored word reads back at 0x20 and drives the `doorbell` output.
- R10: Reads of offsets with no register, including the write-only request port 0x40, return 0. Writes to such offsets and to the read-only offsets 0x30, 0x44 and 0xB0 through 0xB8 change nothing visible.
- R11: During and after reset, `cmd_valid`, `irq`, `host_rvalid` and the overflow flag are 0, `doorbell` is 0, and `cpl_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | AW | Byte offset of the access |
| host_wdata | input | DW | Write data |
| host_rdata | output | DW | Read data, one cycle after the read |
| host_rvalid | output | 1 | Marks the cycle carrying read data |
| cmd_valid | output | 1 | Inbound queue has an entry for the engine |
| cmd_ready | input | 1 | Engine accepts the head entry |
| cmd_addr | output | DW | Command address at the head of the inbound queue |
| cpl_valid | input | 1 | Engine offers a completion tag |
| cpl_ready | output | 1 | Outbound queue has room |
| cpl_tag | input | DW | Completion tag offered by the engine |
| fw_ready | input | 1 | Controller firmware is ready |
| doorbell | output | DW | Last word written to the doorbell offset |
| irq | output | 1 | Reply interrupt request |

## Verification
The bench builds the block with `MAX_CMDS` set to 4 and with locator values that differ from the defaults. The small depth lets a few directed writes and completion pushes fill both queues, so the dropped request, the overflow flag, the low `cpl_ready` and the empty-read value of all ones are all reached quickly. The distinct locator values show that the parameters reach the read multiplexer. A long randomised phase then mixes request writes, reply reads, mask changes and engine handshakes on the same cycles to exercise simultaneous push and pop on each queue.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Byte offsets of the host-visible words
  localparam logic [7:0] OFS_DOORBELL = 8'h20;
  localparam logic [7:0] OFS_STATUS   = 8'h30;
  localparam logic [7:0] OFS_MASK     = 8'h34;
  localparam logic [7:0] OFS_OVF      = 8'h38;
  localparam logic [7:0] OFS_REQUEST  = 8'h40;
  localparam logic [7:0] OFS_REPLY    = 8'h44;
  localparam logic [7:0] OFS_SCRATCH  = 8'hB0;
  localparam logic [7:0] OFS_CFG_TBL  = 8'hB4;
  localparam logic [7:0] OFS_CFG_MEM  = 8'hB8;

  // Bit that is both the pending flag in the status word and the disable bit of the mask
  localparam int unsigned IRQ_BIT = 3;

  localparam logic [31:0] MASK_RESET_WORD = 32'h0000_0008;
  localparam logic [31:0] FW_READY_WORD   = 32'hFFFF_0000;
  localparam logic [31:0] EMPTY_WORD      = 32'hFFFF_FFFF;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic             push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/mbox_csr.sv
module mbox_csr
  import mbox_pkg::*;
#(
  parameter int unsigned AW            = 8,
  parameter int unsigned DW            = 32,
  parameter logic [31:0] CFG_TABLE_LOC = 32'h0000_1000,
  parameter logic [31:0] CFG_MEM_LOC   = 32'h0000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rvalid,
  input  logic          in_full,
  input  logic          ob_empty,
  input  logic [DW-1:0] ob_head,
  input  logic          fw_ready,
  output logic          in_push,
  output logic          ob_pop,
  output logic [DW-1:0] mask_word,
  output logic [DW-1:0] doorbell_word,
  output logic          ovf_flag
);
  localparam logic [AW-1:0] A_DB   = AW'(OFS_DOORBELL);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STATUS);
  localparam logic [AW-1:0] A_MASK = AW'(OFS_MASK);
  localparam logic [AW-1:0] A_OVF  = AW'(OFS_OVF);
  localparam logic [AW-1:0] A_REQ  = AW'(OFS_REQUEST);
  localparam logic [AW-1:0] A_REP  = AW'(OFS_REPLY);
  localparam logic [AW-1:0] A_SCR  = AW'(OFS_SCRATCH);
  localparam logic [AW-1:0] A_CTB  = AW'(OFS_CFG_TBL);
  localparam logic [AW-1:0] A_CMB  = AW'(OFS_CFG_MEM);

  logic          wr_req, rd_rep;
  logic [DW-1:0] rd_next;

  assign wr_req  = host_wr && (host_addr == A_REQ);
  assign rd_rep  = host_rd && (host_addr == A_REP);
  assign in_push = wr_req && !in_full;
  assign ob_pop  = rd_rep && !ob_empty;

  always_comb begin
    case (host_addr)
      A_DB:    rd_next = doorbell_word;
      A_STAT:  rd_next = ob_empty ? '0 : (DW'(1) << IRQ_BIT);
      A_MASK:  rd_next = mask_word;
      A_OVF:   rd_next = DW'(ovf_flag);
      A_REP:   rd_next = ob_empty ? DW'(EMPTY_WORD) : ob_head;
      A_SCR:   rd_next = fw_ready ? DW'(FW_READY_WORD) : '0;
      A_CTB:   rd_next = DW'(CFG_TABLE_LOC);
      A_CMB:   rd_next = DW'(CFG_MEM_LOC);
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) host_rdata <= rd_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_word     <= DW'(MASK_RESET_WORD);
      doorbell_word <= '0;
      ovf_flag      <= 1'b0;
    end else begin
      if (host_wr && host_addr == A_MASK) mask_word     <= host_wdata;
      if (host_wr && host_addr == A_DB)   doorbell_word <= host_wdata;
      if (wr_req && in_full)
        ovf_flag <= 1'b1;
      else if (host_wr && host_addr == A_OVF && host_wdata[0])
        ovf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_regif.sv
module mbox_regif
  import mbox_pkg::*;
#(
  parameter int unsigned AW            = 8,
  parameter int unsigned DW            = 32,
  parameter int unsigned MAX_CMDS      = 16,
  parameter logic [31:0] CFG_TABLE_LOC = 32'h0000_1000,
  parameter logic [31:0] CFG_MEM_LOC   = 32'h0000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rvalid,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [DW-1:0] cmd_addr,
  input  logic          cpl_valid,
  output logic          cpl_ready,
  input  logic [DW-1:0] cpl_tag,
  input  logic          fw_ready,
  output logic [DW-1:0] doorbell,
  output logic          irq
);
  logic          in_push, in_empty, in_full;
  logic          ob_pop, ob_empty, ob_full;
  logic [DW-1:0] ob_head;
  logic [DW-1:0] mask_word;
  logic          ovf_flag;

  mbox_fifo #(.WIDTH(DW), .DEPTH(MAX_CMDS)) u_inq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (in_push),
    .din   (host_wdata),
    .pop   (cmd_ready),
    .dout  (cmd_addr),
    .empty (in_empty),
    .full  (in_full)
  );

  mbox_fifo #(.WIDTH(DW), .DEPTH(MAX_CMDS)) u_obq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (cpl_valid),
    .din   (cpl_tag),
    .pop   (ob_pop),
    .dout  (ob_head),
    .empty (ob_empty),
    .full  (ob_full)
  );

  mbox_csr #(
    .AW(AW), .DW(DW), .CFG_TABLE_LOC(CFG_TABLE_LOC), .CFG_MEM_LOC(CFG_MEM_LOC)
  ) u_csr (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_wr       (host_wr),
    .host_rd       (host_rd),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .host_rdata    (host_rdata),
    .host_rvalid   (host_rvalid),
    .in_full       (in_full),
    .ob_empty      (ob_empty),
    .ob_head       (ob_head),
    .fw_ready      (fw_ready),
    .in_push       (in_push),
    .ob_pop        (ob_pop),
    .mask_word     (mask_word),
    .doorbell_word (doorbell),
    .ovf_flag      (ovf_flag)
  );

  assign cmd_valid = !in_empty;
  assign cpl_ready = !ob_full;
  assign irq       = !ob_empty && !mask_word[IRQ_BIT];
endmodule

// File: rtl/mbox_regif_chk.sv
module mbox_regif_chk
  import mbox_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_wr,
  input logic          host_rd,
  input logic [AW-1:0] host_addr,
  input logic [DW-1:0] host_rdata,
  input logic          host_rvalid,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [DW-1:0] cmd_addr,
  input logic          irq,
  input logic          mask_disable,
  input logic          ob_empty,
  input logic          in_full,
  input logic          ovf_flag
);
  // R5
  rvalid_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid);

  // R5
  no_stray_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> !host_rvalid);

  // R4
  empty_reply_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == AW'(OFS_REPLY) && ob_empty) |=> (host_rdata == {DW{1'b1}}));

  // R7
  irq_respects_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !mask_disable);

  // R7
  irq_needs_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !ob_empty);

  // R2
  overflow_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == AW'(OFS_REQUEST) && in_full) |=> ovf_flag);

  // R1
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr)));
endmodule

bind mbox_regif mbox_regif_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_wr      (host_wr),
  .host_rd      (host_rd),
  .host_addr    (host_addr),
  .host_rdata   (host_rdata),
  .host_rvalid  (host_rvalid),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_addr     (cmd_addr),
  .irq          (irq),
  .mask_disable (mask_word[mbox_pkg::IRQ_BIT]),
  .ob_empty     (ob_empty),
  .in_full      (in_full),
  .ovf_flag     (ovf_flag)
);

// File: tb/tb_mbox_regif.sv
module tb_mbox_regif;
  localparam int unsigned D  = 4;
  localparam logic [31:0] CT = 32'h0000_2A00;
  localparam logic [31:0] CM = 32'h0000_0C40;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        cmd_valid, cmd_ready = 1'b0;
  logic [31:0] cmd_addr;
  logic        cpl_valid = 1'b0, cpl_ready;
  logic [31:0] cpl_tag = '0;
  logic        fw_ready = 1'b0;
  logic [31:0] doorbell;
  logic        irq;

  mbox_regif #(.AW(8), .DW(32), .MAX_CMDS(D), .CFG_TABLE_LOC(CT), .CFG_MEM_LOC(CM)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_tag(cpl_tag), .fw_ready(fw_ready), .doorbell(doorbell), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0] inq[$];
  logic [31:0] obq[$];
  logic [31:0] m_mask = 32'h8, m_db = '0, m_rdata = '0;
  logic        m_ovf = 1'b0, m_rvalid = 1'b0;
  logic [7:0]  m_raddr = '0;

  always @(posedge clk) begin : mdl
    logic [31:0] nd;
    int isz, osz;
    if (!rst_n) begin
      inq.delete(); obq.delete();
      m_mask = 32'h8; m_db = '0; m_ovf = 1'b0; m_rvalid = 1'b0;
    end else begin
      isz = inq.size();
      osz = obq.size();
      m_rvalid = host_rd;
      if (host_rd) begin
        case (host_addr)
          8'h20: nd = m_db;
          8'h30: nd = (osz > 0) ? 32'h8 : 32'h0;
          8'h34: nd = m_mask;
          8'h38: nd = {31'b0, m_ovf};
          8'h44: nd = (osz > 0) ? obq.pop_front() : 32'hFFFF_FFFF;
          8'hB0: nd = fw_ready ? 32'hFFFF_0000 : 32'h0;
          8'hB4: nd = CT;
          8'hB8: nd = CM;
          default: nd = 32'h0;
        endcase
        m_rdata = nd;
        m_raddr = host_addr;
      end
      if (isz > 0 && cmd_ready) void'(inq.pop_front());
      if (host_wr) begin
        case (host_addr)
          8'h20: m_db = host_wdata;
          8'h34: m_mask = host_wdata;
          8'h38: if (host_wdata[0]) m_ovf = 1'b0;
          8'h40: if (isz < int'(D)) inq.push_back(host_wdata); else m_ovf = 1'b1;
          default: ;
        endcase
      end
      if (cpl_valid && osz < int'(D)) obq.push_back(cpl_tag);
    end
  end

  function automatic string rd_tag(logic [7:0] a);
    case (a)
      8'h44: return "R4 reply read";
      8'h30: return "R6 status read";
      8'h34: return "R7 mask read";
      8'h38: return "R2 overflow read";
      8'h20: return "R9 doorbell read";
      8'hB0, 8'hB4, 8'hB8: return "R8 scratch/locator read";
      default: return "R10 unmapped read";
    endcase
  endfunction

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 rvalid", {31'b0, host_rvalid}, {31'b0, m_rvalid});
      if (m_rvalid) chk(rd_tag(m_raddr), host_rdata, m_rdata);
      chk("R1 cmd_valid", {31'b0, cmd_valid}, {31'b0, inq.size() > 0});
      if (inq.size() > 0) chk("R1 cmd_addr", cmd_addr, inq[0]);
      chk("R3 cpl_ready", {31'b0, cpl_ready}, {31'b0, obq.size() < int'(D)});
      chk("R7 irq", {31'b0, irq}, {31'b0, (obq.size() > 0) && !m_mask[3]});
      chk("R9 doorbell port", doorbell, m_db);
    end
  end

  task automatic host_write(logic [7:0] a, logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(logic [7:0] a, logic [31:0] exp, string tag);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    chk(tag, host_rdata, exp);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 cmd_valid reset", {31'b0, cmd_valid}, 32'h0);
    chk("R11 cpl_ready reset", {31'b0, cpl_ready}, 32'h1);
    chk("R11 irq reset", {31'b0, irq}, 32'h0);
    chk("R11 rvalid reset", {31'b0, host_rvalid}, 32'h0);
    chk("R11 doorbell reset", doorbell, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    host_read(8'h34, 32'h8, "R7 mask reset value");
    host_read(8'h38, 32'h0, "R11 overflow reset");
    host_read(8'h30, 32'h0, "R6 status empty");
    host_read(8'h44, 32'hFFFF_FFFF, "R4 empty reply");
    host_read(8'hB0, 32'h0, "R8 scratch not ready");
    fw_ready = 1'b1;
    host_read(8'hB0, 32'hFFFF_0000, "R8 scratch ready");
    host_read(8'hB4, CT, "R8 table locator");
    host_read(8'hB8, CM, "R8 memory locator");

    host_write(8'h20, 32'hA5A5_0001);
    host_read(8'h20, 32'hA5A5_0001, "R9 doorbell readback");
    chk("R9 doorbell output", doorbell, 32'hA5A5_0001);

    host_write(8'h50, 32'hDEAD_BEEF);
    host_read(8'h50, 32'h0, "R10 unmapped reads zero");
    host_read(8'h40, 32'h0, "R10 request port reads zero");
    host_write(8'h30, 32'hFFFF_FFFF);
    host_read(8'h30, 32'h0, "R10 status write ignored");
    host_write(8'hB0, 32'h0);
    host_read(8'hB0, 32'hFFFF_0000, "R10 scratch write ignored");

    // Fill the inbound queue, then overflow it
    cmd_ready = 1'b0;
    for (int i = 0; i < int'(D); i++) host_write(8'h40, 32'h1000 + 32'(i) * 16);
    chk("R1 head after fill", cmd_addr, 32'h1000);
    host_write(8'h40, 32'h0000_0BAD);
    host_read(8'h38, 32'h1, "R2 overflow set");
    host_write(8'h38, 32'h0);
    host_read(8'h38, 32'h1, "R2 write zero keeps flag");
    host_write(8'h38, 32'h1);
    host_read(8'h38, 32'h0, "R2 write one clears flag");
    cmd_ready = 1'b1;
    for (int i = 0; i < int'(D); i++) begin
      chk("R1 arrival order", cmd_addr, 32'h1000 + 32'(i) * 16);
      @(negedge clk);
    end
    chk("R2 dropped write not delivered", {31'b0, cmd_valid}, 32'h0);
    cmd_ready = 1'b0;

    // Fill the outbound queue
    for (int i = 0; i < int'(D); i++) begin
      cpl_valid = 1'b1; cpl_tag = 32'h77 + 32'(i);
      @(negedge clk);
    end
    cpl_tag = 32'hEEEE;
    chk("R3 cpl_ready low when full", {31'b0, cpl_ready}, 32'h0);
    @(negedge clk);
    cpl_valid = 1'b0;
    chk("R7 irq masked", {31'b0, irq}, 32'h0);
    host_read(8'h30, 32'h8, "R6 status pending while masked");
    host_write(8'h34, 32'h0);
    chk("R7 irq enabled", {31'b0, irq}, 32'h1);
    host_read(8'h34, 32'h0, "R7 mask readback");
    for (int i = 0; i < int'(D); i++) host_read(8'h44, 32'h77 + 32'(i), "R4 reply order");
    host_read(8'h44, 32'hFFFF_FFFF, "R4 empty after drain");
    chk("R7 irq clears when empty", {31'b0, irq}, 32'h0);
    chk("R3 cpl_ready back", {31'b0, cpl_ready}, 32'h1);

    // Random mixed traffic, checked by the model each cycle
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      cmd_ready = ($urandom_range(0, 2) == 0);
      cpl_valid = ($urandom_range(0, 1) == 0);
      cpl_tag = $urandom;
      fw_ready = ($urandom_range(0, 7) != 0);
      host_wr = 1'b0; host_rd = 1'b0;
      case (op)
        0, 1: begin host_wr = 1'b1; host_addr = 8'h40; host_wdata = $urandom; end
        2, 3, 4: begin host_rd = 1'b1; host_addr = 8'h44; end
        5: begin host_wr = 1'b1; host_addr = 8'h34; host_wdata = {28'b0, 1'($urandom), 3'b0}; end
        6: begin host_rd = 1'b1; host_addr = 8'h30; end
        7: begin host_rd = 1'b1; host_addr = 8'h38; end
        8: begin host_wr = 1'b1; host_addr = 8'h38; host_wdata = 32'($urandom_range(0, 1)); end
        default: begin host_rd = 1'b1; host_addr = 8'hB0; end
      endcase
      @(negedge clk);
    end
    host_wr = 1'b0; host_rd = 1'b0; cpl_valid = 1'b0; cmd_ready = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule